// File: doc/BRIEF.md
# Ternary Match Table with Priority Encoder

This block holds a table of 32 stored words, each 32 bits wide, and compares a search key against every stored word in the same clock. Each stored word carries a mask: a mask bit set to one makes that bit position a don't-care, so it matches either key value. A search returns a match flag together with one of two result forms. The encoded form gives the index of the matching word. The unencoded form returns the hit status of all 32 words over a 16-bit bus in two consecutive cycles, so that every matching location is visible.

Words are loaded at run time through an address, data and mask write port. A plain write takes two cycles: the accept cycle plus one commit cycle. A write that also loads a mask takes one more cycle. While the block is busy, a write or a search on its inputs is ignored. The first half of an unencoded result also counts as busy, so that the second half cannot be overwritten.

Top module: `tcam_core`

## Requirements
- R1: After reset, busy and resValid are 0 and no stored word is valid. A search then returns matchFlag 0.
- R2: A write (wrEn while busy is 0) with wrMaskEn 0 raises busy for exactly one cycle after the accept edge. The word can be searched from the cycle after that, and its mask is cleared to all-care.
- R3: A write with wrMaskEn 1 raises busy for exactly two cycles after the accept edge and stores wrMask as the word's mask.
- R4: A search accepted while idle (srchEn, busy 0, wrEn 0) sets matchFlag when some valid word equals the key on every bit whose mask bit is 0.
- R5: A mask bit of 1 (don't-care) never stops that word from matching, whatever the key holds in that position.
- R6: With srchUnenc 0, resValid is 1 with resUnenc 0 in exactly the one cycle after the accept edge. matchAddr gives the lowest matching index and hitVec is 0.
- R7: With srchUnenc 1, resValid and resUnenc are 1 for the two cycles after the accept edge. In the first cycle resPhase is 0 and hitVec bit k shows word k. In the second cycle resPhase is 1 and hitVec bit k shows word 16+k. busy is 1 during the first cycle.
- R8: wrEn and srchEn have no effect while busy is 1: no word changes and no result appears.
- R9: When wrEn and srchEn are both high in an idle cycle, the write is performed and the search is dropped.
- R10: When no word matches, matchFlag, matchAddr and hitVec are all 0 in the result cycles.
- R11: Rewriting a word with a plain write replaces the mask it held before with all-care.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write request |
| wrMaskEn | input | 1 | Write also loads the don't-care mask |
| wrAddr | input | 5 | Index of the word to write |
| wrData | input | 32 | Word value to store |
| wrMask | input | 32 | Don't-care mask, 1 = ignore bit |
| srchEn | input | 1 | Search request |
| srchUnenc | input | 1 | 1 = unencoded two-cycle result, 0 = encoded |
| srchKey | input | 32 | Search key |
| busy | output | 1 | Requests are ignored while high |
| resValid | output | 1 | A result is presented this cycle |
| resUnenc | output | 1 | Current result is in unencoded form |
| resPhase | output | 1 | Unencoded half: 0 = words 0..15, 1 = words 16..31 |
| matchFlag | output | 1 | At least one word matched the key |
| matchAddr | output | 5 | Lowest matching index (encoded form) |
| hitVec | output | 16 | Per-word hit bits of the current half (unencoded form) |

## Verification
The assertions check the handshake timing on every cycle: how long busy stays high after each kind of write, the single result cycle of an encoded search, the two-phase order of an unencoded result with busy over its first half, and that every result traces back to an accepted search. They also check that a no-match result carries a zero address and a zero hit vector. The bench scenarios cover what depends on stored contents. A reference table in the bench predicts which words match under don't-care masks, which index wins when several words match, and which hit bits appear in each half. The scenarios also show that writes and searches attempted while busy leave the table unchanged, and that a plain rewrite clears an earlier mask.

// File: rtl/tcam_pkg.sv
package tcam_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_WR_DATA = 2'd1,
    ST_WR_MASK = 2'd2,
    ST_HIT_LO  = 2'd3
  } tcamState_t;

  typedef struct packed {
    logic capWr;       // latch write address, data and mask
    logic commitData;  // store data, set valid, clear mask
    logic commitMask;  // store the held mask
    logic capSrch;     // register hit vector of an accepted search
    logic advPhase;    // move an unencoded result to its upper half
  } tcamStrobe_t;

endpackage

// File: rtl/tcam_ctrl.sv
module tcam_ctrl
  import tcam_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic        wrMaskEn,
  input  logic        srchEn,
  input  logic        srchUnenc,
  output tcamStrobe_t strb,
  output logic        busy
);

  tcamState_t stateQ, stateD;
  logic       maskPendQ;
  logic       wrGo, srGo;

  assign busy = (stateQ != ST_IDLE);
  assign wrGo = wrEn && !busy;
  assign srGo = srchEn && !busy && !wrEn;

  always_comb begin
    stateD = stateQ;
    case (stateQ)
      ST_IDLE: begin
        if (wrGo)                   stateD = ST_WR_DATA;
        else if (srGo && srchUnenc) stateD = ST_HIT_LO;
      end
      ST_WR_DATA: stateD = maskPendQ ? ST_WR_MASK : ST_IDLE;
      ST_WR_MASK: stateD = ST_IDLE;
      ST_HIT_LO:  stateD = ST_IDLE;
      default:    stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ    <= ST_IDLE;
      maskPendQ <= 1'b0;
    end else begin
      stateQ <= stateD;
      if (wrGo) maskPendQ <= wrMaskEn;
    end
  end

  always_comb begin
    strb            = '0;
    strb.capWr      = wrGo;
    strb.commitData = (stateQ == ST_WR_DATA);
    strb.commitMask = (stateQ == ST_WR_MASK);
    strb.capSrch    = srGo;
    strb.advPhase   = (stateQ == ST_HIT_LO);
  end

endmodule

// File: rtl/tcam_row_cmp.sv
module tcam_row_cmp #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] key,
  input  logic [WIDTH-1:0] data,
  input  logic [WIDTH-1:0] mask,
  input  logic             valid,
  output logic             hit
);

  logic [WIDTH-1:0] diff;

  assign diff = (key ^ data) & ~mask;
  assign hit  = valid && (diff == '0);

endmodule

// File: rtl/tcam_array.sv
module tcam_array
  import tcam_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int WIDTH   = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  tcamStrobe_t                strb,
  input  logic [$clog2(ENTRIES)-1:0] wrAddr,
  input  logic [WIDTH-1:0]           wrData,
  input  logic [WIDTH-1:0]           wrMask,
  input  logic                       srchUnenc,
  input  logic [WIDTH-1:0]           srchKey,
  output logic                       resValid,
  output logic                       resUnenc,
  output logic                       resPhase,
  output logic                       matchFlag,
  output logic [$clog2(ENTRIES)-1:0] matchAddr,
  output logic [ENTRIES/2-1:0]       hitVec
);

  localparam int ADDR_W = $clog2(ENTRIES);
  localparam int HALF   = ENTRIES / 2;

  logic [WIDTH-1:0]   entData [ENTRIES];
  logic [WIDTH-1:0]   entMask [ENTRIES];
  logic [ENTRIES-1:0] entValid;

  logic [ADDR_W-1:0]  pAddrQ;
  logic [WIDTH-1:0]   pDataQ;
  logic [WIDTH-1:0]   pMaskQ;

  logic [ENTRIES-1:0] hitNow;
  logic [ENTRIES-1:0] hitQ;
  logic               resValidQ, resUnencQ, resPhaseQ;
  logic [ADDR_W-1:0]  encIdx;

  // parallel compare, one cell per stored word
  for (genvar g = 0; g < ENTRIES; g++) begin : g_row
    tcam_row_cmp #(.WIDTH(WIDTH)) u_cmp (
      .key   (srchKey),
      .data  (entData[g]),
      .mask  (entMask[g]),
      .valid (entValid[g]),
      .hit   (hitNow[g])
    );
  end

  // write hold registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pAddrQ <= '0;
      pDataQ <= '0;
      pMaskQ <= '0;
    end else if (strb.capWr) begin
      pAddrQ <= wrAddr;
      pDataQ <= wrData;
      pMaskQ <= wrMask;
    end
  end

  // storage: data and mask committed in separate cycles
  always_ff @(posedge clk) begin
    if (!rstN) begin
      entValid <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        entData[i] <= '0;
        entMask[i] <= '0;
      end
    end else begin
      if (strb.commitData) begin
        entData[pAddrQ]  <= pDataQ;
        entMask[pAddrQ]  <= '0;
        entValid[pAddrQ] <= 1'b1;
      end else if (strb.commitMask) begin
        entMask[pAddrQ]  <= pMaskQ;
      end
    end
  end

  // result registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      hitQ      <= '0;
      resValidQ <= 1'b0;
      resUnencQ <= 1'b0;
      resPhaseQ <= 1'b0;
    end else if (strb.capSrch) begin
      hitQ      <= hitNow;
      resValidQ <= 1'b1;
      resUnencQ <= srchUnenc;
      resPhaseQ <= 1'b0;
    end else if (strb.advPhase) begin
      resValidQ <= 1'b1;
      resPhaseQ <= 1'b1;
    end else begin
      resValidQ <= 1'b0;
      resPhaseQ <= 1'b0;
    end
  end

  // lowest index wins
  always_comb begin
    encIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hitQ[i]) encIdx = ADDR_W'(i);
    end
  end

  assign resValid  = resValidQ;
  assign resUnenc  = resValidQ && resUnencQ;
  assign resPhase  = resValidQ && resUnencQ && resPhaseQ;
  assign matchFlag = resValidQ && (hitQ != '0);
  assign matchAddr = (resValidQ && !resUnencQ) ? encIdx : '0;
  assign hitVec    = !(resValidQ && resUnencQ) ? '0 :
                     (resPhaseQ ? hitQ[ENTRIES-1:HALF] : hitQ[HALF-1:0]);

endmodule

// File: rtl/tcam_core.sv
module tcam_core
  import tcam_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int WIDTH   = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       wrEn,
  input  logic                       wrMaskEn,
  input  logic [$clog2(ENTRIES)-1:0] wrAddr,
  input  logic [WIDTH-1:0]           wrData,
  input  logic [WIDTH-1:0]           wrMask,
  input  logic                       srchEn,
  input  logic                       srchUnenc,
  input  logic [WIDTH-1:0]           srchKey,
  output logic                       busy,
  output logic                       resValid,
  output logic                       resUnenc,
  output logic                       resPhase,
  output logic                       matchFlag,
  output logic [$clog2(ENTRIES)-1:0] matchAddr,
  output logic [ENTRIES/2-1:0]       hitVec
);

  tcamStrobe_t strb;

  tcam_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .wrMaskEn  (wrMaskEn),
    .srchEn    (srchEn),
    .srchUnenc (srchUnenc),
    .strb      (strb),
    .busy      (busy)
  );

  tcam_array #(.ENTRIES(ENTRIES), .WIDTH(WIDTH)) u_array (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .wrMask    (wrMask),
    .srchUnenc (srchUnenc),
    .srchKey   (srchKey),
    .resValid  (resValid),
    .resUnenc  (resUnenc),
    .resPhase  (resPhase),
    .matchFlag (matchFlag),
    .matchAddr (matchAddr),
    .hitVec    (hitVec)
  );

endmodule

// File: rtl/tcam_core_chk.sv
module tcam_core_chk #(
  parameter int ENTRIES = 32
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       wrEn,
  input logic                       wrMaskEn,
  input logic                       srchEn,
  input logic                       busy,
  input logic                       resValid,
  input logic                       resUnenc,
  input logic                       resPhase,
  input logic                       matchFlag,
  input logic [$clog2(ENTRIES)-1:0] matchAddr,
  input logic [ENTRIES/2-1:0]       hitVec
);

  p_plain_write_busy_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !busy && !wrMaskEn) |=> busy ##1 !busy);

  p_mask_write_busy_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !busy && wrMaskEn) |=> busy ##1 busy ##1 !busy);

  p_enc_result_r6: assert property (@(posedge clk) disable iff (!rstN)
    (srchEn && !busy && !wrEn) |=> resValid && !resPhase);

  p_enc_no_vec_r6: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && !resUnenc) |-> (hitVec == '0));

  p_phase_order_r7: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && resUnenc && !resPhase) |=> (resValid && resUnenc && resPhase));

  p_lo_half_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && resUnenc && !resPhase) |-> busy);

  p_result_source_r8: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && !resPhase) |-> $past(srchEn && !busy && !wrEn));

  p_nomatch_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && !matchFlag) |-> (matchAddr == '0 && hitVec == '0));

endmodule

bind tcam_core tcam_core_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .wrEn      (wrEn),
  .wrMaskEn  (wrMaskEn),
  .srchEn    (srchEn),
  .busy      (busy),
  .resValid  (resValid),
  .resUnenc  (resUnenc),
  .resPhase  (resPhase),
  .matchFlag (matchFlag),
  .matchAddr (matchAddr),
  .hitVec    (hitVec)
);

// File: tb/tcam_core_tb_top.sv
`timescale 1ns/1ps
module tcam_core_tb_top;

  localparam int ENTRIES = 32;
  localparam int WIDTH   = 32;
  localparam int HALF    = ENTRIES / 2;

  typedef struct {
    int          due;
    logic [23:0] val;   // {flag, addr, unenc, phase, vec}
    string       tag;
  } expItem_t;

  logic             clk = 0;
  logic             rstN = 0;
  logic             wrEn = 0, wrMaskEn = 0, srchEn = 0, srchUnenc = 0;
  logic [4:0]       wrAddr = '0;
  logic [WIDTH-1:0] wrData = '0, wrMask = '0, srchKey = '0;
  logic             busy, resValid, resUnenc, resPhase, matchFlag;
  logic [4:0]       matchAddr;
  logic [HALF-1:0]  hitVec;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;
  expItem_t expQ[$];

  logic [WIDTH-1:0]   mData [ENTRIES];
  logic [WIDTH-1:0]   mMask [ENTRIES];
  logic [ENTRIES-1:0] mValid = '0;

  always #2 clk = ~clk;   // 250 MHz
  always @(posedge clk) cyc++;

  tcam_core #(.ENTRIES(ENTRIES), .WIDTH(WIDTH)) dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrMaskEn(wrMaskEn), .wrAddr(wrAddr),
    .wrData(wrData), .wrMask(wrMask), .srchEn(srchEn), .srchUnenc(srchUnenc),
    .srchKey(srchKey), .busy(busy), .resValid(resValid), .resUnenc(resUnenc),
    .resPhase(resPhase), .matchFlag(matchFlag), .matchAddr(matchAddr), .hitVec(hitVec)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [ENTRIES-1:0] modelHits(input logic [WIDTH-1:0] key);
    logic [ENTRIES-1:0] h = '0;
    for (int i = 0; i < ENTRIES; i++)
      h[i] = mValid[i] && (((key ^ mData[i]) & ~mMask[i]) == '0);
    return h;
  endfunction

  // driver: write one word, checking busy length (R2 plain, R3 masked)
  task automatic wrWord(input int addr, input logic [WIDTH-1:0] d, input logic [WIDTH-1:0] m,
                        input bit masked, input bit inject);
    @(negedge clk);
    chk(busy == 1'b0, "R2 idle before write", 32'(busy), 0);
    wrEn = 1; wrMaskEn = masked; wrAddr = 5'(addr); wrData = d; wrMask = m;
    @(negedge clk);
    wrEn = 0; wrMaskEn = 0;
    chk(busy == 1'b1, masked ? "R3 busy cycle 1" : "R2 busy cycle 1", 32'(busy), 1);
    if (inject) begin
      // R8: attempts while busy must be ignored
      srchEn = 1; srchUnenc = 0; srchKey = 32'hA5A5_0001;
      wrEn = 1; wrAddr = 5'd7; wrData = 32'h7777_7777;
    end
    if (masked) begin
      @(negedge clk);
      chk(busy == 1'b1, "R3 busy cycle 2", 32'(busy), 1);
    end
    @(negedge clk);
    srchEn = 0; wrEn = 0;
    chk(busy == 1'b0, masked ? "R3 busy released" : "R2 busy released", 32'(busy), 0);
    mData[addr] = d;
    mMask[addr] = masked ? m : '0;
    mValid[addr] = 1'b1;
  endtask

  // driver: issue a search and push the expected results
  task automatic search(input logic [WIDTH-1:0] key, input bit unenc, input string tag);
    logic [ENTRIES-1:0] h;
    logic [4:0] lowIdx;
    expItem_t it;
    @(negedge clk);
    srchEn = 1; srchUnenc = unenc; srchKey = key;
    h = modelHits(key);
    lowIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) if (h[i]) lowIdx = 5'(i);
    if (!unenc) begin
      it.due = cyc + 1; it.tag = tag;
      it.val = {(h != '0), (h != '0) ? lowIdx : 5'd0, 1'b0, 1'b0, 16'h0};
      expQ.push_back(it);
    end else begin
      it.due = cyc + 1; it.tag = tag;
      it.val = {(h != '0), 5'd0, 1'b1, 1'b0, h[HALF-1:0]};
      expQ.push_back(it);
      it.due = cyc + 2;
      it.val = {(h != '0), 5'd0, 1'b1, 1'b1, h[ENTRIES-1:HALF]};
      expQ.push_back(it);
    end
    @(negedge clk);
    srchEn = 0;
    if (unenc) chk(busy == 1'b1, "R7 busy during lower half", 32'(busy), 1);
  endtask

  // monitor: compare results against the scoreboard queue
  always @(posedge clk) begin
    #1;
    if (rstN && !done) begin
      if (resValid) begin
        if (expQ.size() == 0) begin
          chk(1'b0, "R8/R9 unexpected result", 32'(matchAddr), 0);
        end else begin
          expItem_t it;
          logic [23:0] act;
          it = expQ.pop_front();
          act = {matchFlag, matchAddr, resUnenc, resPhase, hitVec};
          chk(it.due == cyc, {it.tag, " result cycle"}, 32'(cyc), 32'(it.due));
          chk(act == it.val, it.tag, 32'(act), 32'(it.val));
        end
      end else if (expQ.size() > 0 && expQ[0].due <= cyc) begin
        chk(1'b0, {expQ[0].tag, " missing result"}, 0, 1);
        void'(expQ.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < ENTRIES; i++) begin mData[i] = '0; mMask[i] = '0; end
    repeat (3) @(negedge clk);
    chk(busy == 0 && resValid == 0, "R1 outputs in reset", {30'd0, busy, resValid}, 0);
    rstN = 1;
    @(negedge clk);
    chk(busy == 0 && resValid == 0, "R1 outputs after reset", {30'd0, busy, resValid}, 0);
    search(32'h0000_0000, 0, "R1 empty table no match");
    search(32'h1234_5678, 1, "R10 empty unencoded");

    wrWord(5, 32'hA5A5_0001, '0, 0, 0);
    search(32'hA5A5_0001, 0, "R4 exact match");
    search(32'hA5A5_0003, 0, "R10 one bit off");

    wrWord(9, 32'h1234_0000, 32'h0000_FFFF, 1, 0);
    search(32'h1234_BEEF, 0, "R5 masked low half");
    search(32'h1235_0000, 0, "R10 care bit differs");

    wrWord(20, 32'hA5A5_0001, '0, 0, 0);
    search(32'hA5A5_0001, 0, "R6 lowest index wins");
    search(32'hA5A5_0001, 1, "R7 two halves");

    // R8: requests during a masked write are ignored
    wrWord(3, 32'hFFFF_0000, '0, 1, 1);
    search(32'h7777_7777, 0, "R8 write while busy dropped");
    search(32'hFFFF_0000, 0, "R3 masked write zero mask");

    // R9: write wins over simultaneous search
    @(negedge clk);
    wrEn = 1; wrMaskEn = 0; wrAddr = 5'd1; wrData = 32'hCAFE_0000;
    srchEn = 1; srchUnenc = 0; srchKey = 32'hA5A5_0001;
    @(negedge clk);
    wrEn = 0; srchEn = 0;
    chk(busy == 1'b1, "R9 write taken", 32'(busy), 1);
    @(negedge clk);
    mData[1] = 32'hCAFE_0000; mMask[1] = '0; mValid[1] = 1'b1;
    search(32'hCAFE_0000, 0, "R9 written word present");

    // R11: plain rewrite clears the old mask
    wrWord(9, 32'h1234_0000, '0, 0, 0);
    search(32'h1234_BEEF, 0, "R11 old mask gone");
    search(32'h1234_0000, 0, "R11 exact after rewrite");

    // all don't-care word in the upper half
    wrWord(31, 32'h0, 32'hFFFF_FFFF, 1, 0);
    search(32'hDEAD_BEEF, 0, "R5 full don't-care");
    search(32'hDEAD_BEEF, 1, "R7 upper half only");
    search(32'hA5A5_0001, 1, "R7 several hits both halves");
    search(32'hA5A5_0001, 0, "R6 lowest of several");

    repeat (4) @(negedge clk);
    chk(expQ.size() == 0, "R6 all results seen", 32'(expQ.size()), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule